// File: doc/BRIEF.md
# Channel-Interleave Address Swizzle Unit

This unit sits on the address path in front of an interleaved memory system. It lets a client reach a tiled surface with the same bit-6 channel selection that the graphics engine uses. A configuration word, written through a plain write strobe, describes how the memory channels are interleaved. From that word and a product-family select, the unit derives one swizzle mode for X-tiled surfaces and one for Y-tiled surfaces.

Each request carries a byte address, a tiling mode and a stride. The response carries four things. The first is the address with bit 6 XORed by the higher address bits the active mode names. The second is the effective tiling and the third the effective stride. The fourth is the mode code that software sees. That reported code never shows the bit-17 term.

Requests flow through a valid/ready pair with no storage on the path. The response is valid in the same cycle as the request. Back-pressure from the response side reaches the request side in the same cycle. A producer that sees `req_valid` high and `req_ready` low must hold its request unchanged until the handshake completes. The configuration and family-select pins are plain control inputs.

Top module: `swz_unit`

## Requirements
- R1: A write with `cfg_we` high loads `cfg_wdata` on the rising clock edge, and requests see the new word from the following cycle. Reset loads an all-zero word.
- R2: The word's field [1:0] selects the channel arrangement: 0 single, 1 asymmetric dual, 2 interleaved dual, 3 reserved. With `gen_sel`=1 and a field value other than 2, both X and Y modes are none (code 0), and tiled addresses pass through unchanged.
- R3: Interleaved arrangement with word bit 2 (channel-XOR off) set: an X request flips address bit 6 by bit9^bit10 and reports code 2 (9_10). A Y request flips bit 6 by bit 9 and reports code 1 (9).
- R4: Interleaved arrangement with bit 2 clear and bit 3 (high-bit select) clear: X flips bit 6 by bit9^bit10^bit11 and reports code 4 (9_10_11). Y flips it by bit9^bit11 and reports code 3 (9_11).
- R5: Interleaved arrangement with bit 2 clear and bit 3 set: X flips bit 6 by bit9^bit10^bit17 but reports code 2. Y flips it by bit9^bit17 but reports code 1. Codes 5 and 6 are never reported.
- R6: With `gen_sel`=1 and a word of all ones, both modes are unknown. A tiled request is then returned as linear (tiling 0), with stride 0, code 0, and the address unchanged. Code 7 is never reported.
- R7: Tiling encoding is 0 linear, 1 X, 2 Y, 3 treated as linear. A linear request returns its address unchanged, code 0, stride 0 and tiling 0, whatever the configuration.
- R8: `gen_sel` 0 and 3 force none for both orientations. `gen_sel` 2 forces X to code 2 and Y to code 1, with the matching address flips. In all three cases the configuration word is ignored.
- R9: Only address bit 6 may differ between request and response. A tiled request that is not turned linear keeps its tiling and stride.
- R10: `rsp_valid` equals `req_valid` and `req_ready` equals `rsp_ready` in the same cycle. The response fields are a combinational function of the request and the registered configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to load |
| gen_sel | input | 2 | Product-family select (0 oldest, 1 configured, 2 fixed, 3 newest) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_addr | input | 32 | Request byte address |
| req_tiling | input | 2 | Request tiling mode |
| req_stride | input | 16 | Request stride |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_addr | output | 32 | Swizzled byte address |
| rsp_tiling | output | 2 | Effective tiling mode |
| rsp_stride | output | 16 | Effective stride |
| rsp_mode | output | 3 | Reported swizzle-mode code |

## Verification
On every cycle, the assertions check several properties. Only bit 6 ever moves. A linear response is clean: stride zero, code none and the address unchanged. The reduced codes and the unknown code never reach the output. The fixed families ignore the word. A configuration write lands one cycle later. Which higher bits feed the bit-6 flip for each arrangement and orientation, and how an all-ones word turns a tiled request into a linear one, are shown only by the bench's directed scenarios. Those scenarios drive address patterns that toggle bits 9, 10, 11 and 17 separately.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [2:0] {
    SWZ_NONE      = 3'd0,
    SWZ_9         = 3'd1,
    SWZ_9_10      = 3'd2,
    SWZ_9_11      = 3'd3,
    SWZ_9_10_11   = 3'd4,
    SWZ_9_17      = 3'd5,
    SWZ_9_10_17   = 3'd6,
    SWZ_UNKNOWN   = 3'd7
  } swz_mode_e;

  typedef enum logic [1:0] {
    TILE_LIN = 2'd0,
    TILE_X   = 2'd1,
    TILE_Y   = 2'd2,
    TILE_RSV = 2'd3
  } tile_e;

  typedef enum logic [1:0] {
    FAM_OLD   = 2'd0,
    FAM_CFG   = 2'd1,
    FAM_FIXED = 2'd2,
    FAM_NEW   = 2'd3
  } fam_e;

  typedef enum logic [1:0] {
    ARR_SINGLE = 2'd0,
    ARR_ASYM   = 2'd1,
    ARR_ILV    = 2'd2,
    ARR_RSV    = 2'd3
  } arr_e;

endpackage

// File: rtl/swz_cfg_decode.sv
module swz_cfg_decode
  import swz_pkg::*;
#(
  parameter int CW         = 32,
  parameter int ARR_LSB    = 0,
  parameter int XOR_OFF_B  = 2,
  parameter int HI_SEL_B   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_wdata,
  input  logic [1:0]    gen_sel,
  output swz_mode_e     x_mode,
  output swz_mode_e     y_mode
);
  localparam logic [CW-1:0] ALL_ONES = {CW{1'b1}};

  logic [CW-1:0] cfg_q;
  arr_e          arr;
  logic          xor_off;
  logic          hi_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  assign arr     = arr_e'(cfg_q[ARR_LSB +: 2]);
  assign xor_off = cfg_q[XOR_OFF_B];
  assign hi_sel  = cfg_q[HI_SEL_B];

  always_comb begin
    x_mode = SWZ_NONE;
    y_mode = SWZ_NONE;
    unique case (fam_e'(gen_sel))
      FAM_FIXED: begin
        x_mode = SWZ_9_10;
        y_mode = SWZ_9;
      end
      FAM_CFG: begin
        if (cfg_q == ALL_ONES) begin
          x_mode = SWZ_UNKNOWN;
          y_mode = SWZ_UNKNOWN;
        end else if (arr == ARR_ILV) begin
          if (xor_off) begin
            x_mode = SWZ_9_10;
            y_mode = SWZ_9;
          end else if (!hi_sel) begin
            x_mode = SWZ_9_10_11;
            y_mode = SWZ_9_11;
          end else begin
            x_mode = SWZ_9_10_17;
            y_mode = SWZ_9_17;
          end
        end
      end
      default: begin
        x_mode = SWZ_NONE;
        y_mode = SWZ_NONE;
      end
    endcase
  end

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_q == $past(cfg_wdata)); // R1

endmodule

// File: rtl/swz_mode_resolve.sv
module swz_mode_resolve
  import swz_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic [1:0]    tiling_i,
  input  logic [SW-1:0] stride_i,
  input  swz_mode_e     x_mode,
  input  swz_mode_e     y_mode,
  output swz_mode_e     apply_mode,
  output swz_mode_e     report_mode,
  output tile_e         tiling_o,
  output logic [SW-1:0] stride_o
);
  swz_mode_e pick;

  always_comb begin
    unique case (tile_e'(tiling_i))
      TILE_X:  pick = x_mode;
      TILE_Y:  pick = y_mode;
      default: pick = SWZ_NONE;
    endcase
  end

  always_comb begin
    apply_mode  = pick;
    report_mode = pick;
    tiling_o    = tile_e'(tiling_i);
    stride_o    = stride_i;
    if (pick == SWZ_9_17)    report_mode = SWZ_9;
    if (pick == SWZ_9_10_17) report_mode = SWZ_9_10;
    if (pick == SWZ_UNKNOWN || tiling_o == TILE_LIN || tiling_o == TILE_RSV) begin
      apply_mode  = SWZ_NONE;
      report_mode = SWZ_NONE;
      tiling_o    = TILE_LIN;
      stride_o    = '0;
    end
  end

endmodule

// File: rtl/swz_addr_xor.sv
module swz_addr_xor
  import swz_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  swz_mode_e     mode,
  output logic [AW-1:0] addr_o
);
  localparam int TGT = 6;

  logic b9, b10, b11, b17;
  logic flip;

  assign b9  = addr_i[9];
  assign b10 = addr_i[10];

  generate
    if (AW > 11) begin : g_b11
      assign b11 = addr_i[11];
    end else begin : g_no_b11
      assign b11 = 1'b0;
    end
    if (AW > 17) begin : g_b17
      assign b17 = addr_i[17];
    end else begin : g_no_b17
      assign b17 = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (mode)
      SWZ_9:        flip = b9;
      SWZ_9_10:     flip = b9 ^ b10;
      SWZ_9_11:     flip = b9 ^ b11;
      SWZ_9_10_11:  flip = b9 ^ b10 ^ b11;
      SWZ_9_17:     flip = b9 ^ b17;
      SWZ_9_10_17:  flip = b9 ^ b10 ^ b17;
      default:      flip = 1'b0;
    endcase
  end

  always_comb begin
    addr_o      = addr_i;
    addr_o[TGT] = addr_i[TGT] ^ flip;
  end

endmodule

// File: rtl/swz_unit.sv
module swz_unit
  import swz_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_wdata,
  input  logic [1:0]    gen_sel,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_tiling,
  input  logic [SW-1:0] req_stride,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_addr,
  output logic [1:0]    rsp_tiling,
  output logic [SW-1:0] rsp_stride,
  output logic [2:0]    rsp_mode
);
  swz_mode_e x_mode, y_mode, apply_mode, report_mode;
  tile_e     tiling_eff;

  swz_cfg_decode #(.CW(CW)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .gen_sel   (gen_sel),
    .x_mode    (x_mode),
    .y_mode    (y_mode)
  );

  swz_mode_resolve #(.SW(SW)) u_res (
    .tiling_i    (req_tiling),
    .stride_i    (req_stride),
    .x_mode      (x_mode),
    .y_mode      (y_mode),
    .apply_mode  (apply_mode),
    .report_mode (report_mode),
    .tiling_o    (tiling_eff),
    .stride_o    (rsp_stride)
  );

  swz_addr_xor #(.AW(AW)) u_xor (
    .addr_i (req_addr),
    .mode   (apply_mode),
    .addr_o (rsp_addr)
  );

  assign rsp_tiling = tiling_eff;
  assign rsp_mode   = report_mode;
  assign rsp_valid  = req_valid;
  assign req_ready  = rsp_ready;

  AST_ONLY_BIT6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_addr[AW-1:7] == req_addr[AW-1:7]) && (rsp_addr[5:0] == req_addr[5:0])); // R9

  AST_LINEAR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_tiling == 2'd0) |-> (rsp_stride == '0 && rsp_mode == 3'd0 && rsp_addr == req_addr)); // R7

  AST_NO_HI17_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_mode != 3'd5 && rsp_mode != 3'd6)); // R5

  AST_NO_UNKNOWN_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_mode != 3'd7); // R6

  AST_FIXED_FAMILY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && gen_sel != 2'd1 && req_tiling == 2'd1) |->
      rsp_mode == ((gen_sel == 2'd2) ? 3'd2 : 3'd0)); // R8

  AST_TILED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_tiling != 2'd0) |-> (rsp_tiling == req_tiling && rsp_stride == req_stride)); // R9

endmodule

// File: tb/swz_unit_tb.sv
module swz_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  gen_sel = 2'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_tiling = '0;
  logic [15:0] req_stride = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic [1:0]  rsp_tiling;
  logic [15:0] rsp_stride;
  logic [2:0]  rsp_mode;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] cur_cfg = '0;
  bit done = 0;

  always #5 clk = ~clk;

  swz_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .gen_sel(gen_sel), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_tiling(req_tiling), .req_stride(req_stride),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_tiling(rsp_tiling), .rsp_stride(rsp_stride), .rsp_mode(rsp_mode)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Mode per requirements R2-R6, R8 (code values as stated there).
  function automatic logic [2:0] model_mode(input logic [31:0] w, input logic [1:0] g, input bit is_y);
    if (g == 2'd0 || g == 2'd3) return 3'd0;
    if (g == 2'd2) return is_y ? 3'd1 : 3'd2;
    if (w == 32'hFFFF_FFFF) return 3'd7;
    if (w[1:0] != 2'd2) return 3'd0;
    if (w[2]) return is_y ? 3'd1 : 3'd2;
    if (!w[3]) return is_y ? 3'd3 : 3'd4;
    return is_y ? 3'd5 : 3'd6;
  endfunction

  function automatic logic model_flip(input logic [2:0] m, input logic [31:0] a);
    case (m)
      3'd1: return a[9];
      3'd2: return a[9] ^ a[10];
      3'd3: return a[9] ^ a[11];
      3'd4: return a[9] ^ a[10] ^ a[11];
      3'd5: return a[9] ^ a[17];
      3'd6: return a[9] ^ a[10] ^ a[17];
      default: return 1'b0;
    endcase
  endfunction

  task automatic send(input string req, input logic [31:0] a, input logic [1:0] t, input logic [15:0] s);
    logic [2:0]  m;
    logic [31:0] ea;
    logic [2:0]  er;
    logic [1:0]  et;
    logic [15:0] es;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_tiling = t; req_stride = s;
    #1;
    m  = (t == 2'd1 || t == 2'd2) ? model_mode(cur_cfg, gen_sel, t == 2'd2) : 3'd0;
    if (m == 3'd7) m = 3'd0;
    ea = a; ea[6] = a[6] ^ model_flip(m, a);
    er = (m == 3'd5) ? 3'd1 : (m == 3'd6) ? 3'd2 : m;
    et = (m == 3'd0 && !(t == 2'd1 || t == 2'd2)) ? 2'd0 : t;
    if ((t == 2'd1 || t == 2'd2) && model_mode(cur_cfg, gen_sel, t == 2'd2) == 3'd7) et = 2'd0;
    es = (et == 2'd0) ? 16'd0 : s;
    check({req, " addr"},   rsp_addr, ea);
    check({req, " mode"},   {29'd0, rsp_mode}, {29'd0, er});
    check({req, " tiling"}, {30'd0, rsp_tiling}, {30'd0, et});
    check({req, " stride"}, {16'd0, rsp_stride}, {16'd0, es});
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0; cur_cfg = w;
  endtask

  task automatic sweep(input string req);
    send(req, 32'h0000_0200, 2'd1, 16'd512);
    send(req, 32'h0000_0600, 2'd1, 16'd512);
    send(req, 32'h0000_0A40, 2'd2, 16'd128);
    send(req, 32'h0002_0000, 2'd1, 16'd256);
    send(req, 32'h0002_0200, 2'd2, 16'd256);
    send(req, 32'h0000_0C00, 2'd2, 16'd64);
  endtask

  task automatic t_reset;
    // R1: reset word is zero, so interleave swizzling is off
    send("R1 reset", 32'h0000_0640, 2'd1, 16'd512);
    check("R10 valid follows", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic t_nonilv;
    write_cfg(32'h0000_0001); sweep("R2 asym");
    write_cfg(32'h0000_000F); sweep("R2 reserved");
  endtask

  task automatic t_xoroff;
    write_cfg(32'h0000_0006); sweep("R3 xoroff");
  endtask

  task automatic t_b11;
    write_cfg(32'h0000_0002); sweep("R4 bit11");
    send("R4 y bit11", 32'h0000_0800, 2'd2, 16'd512);
  endtask

  task automatic t_b17;
    write_cfg(32'h0000_000A); sweep("R5 bit17");
    send("R5 x bit17 only", 32'h0002_0000, 2'd1, 16'd512);
  endtask

  task automatic t_unknown;
    write_cfg(32'hFFFF_FFFF);
    send("R6 unknown x", 32'h0000_0640, 2'd1, 16'd512);
    send("R6 unknown y", 32'h0002_0240, 2'd2, 16'd128);
  endtask

  task automatic t_linear;
    write_cfg(32'h0000_0002);
    send("R7 linear", 32'h0002_0E40, 2'd0, 16'd999);
    send("R7 rsv tiling", 32'h0002_0E40, 2'd3, 16'd77);
  endtask

  task automatic t_family;
    write_cfg(32'h0000_000A);
    for (int g = 0; g < 4; g++) begin
      gen_sel = 2'(g);
      sweep("R8 family");
    end
    write_cfg(32'hFFFF_FFFF);
    gen_sel = 2'd2;
    send("R8 fixed ignores word", 32'h0000_0400, 2'd1, 16'd512);
    gen_sel = 2'd1;
  endtask

  task automatic t_cfg_timing;
    // R1: new word not visible in the write cycle, visible after the edge
    write_cfg(32'h0000_0006);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'h0000_0000;
    req_valid = 1'b1; req_addr = 32'h0000_0200; req_tiling = 2'd1;
    #1;
    check("R1 old word before edge", rsp_addr, 32'h0000_0240);
    @(negedge clk);
    cfg_we = 1'b0; cur_cfg = '0;
    #1;
    check("R1 new word after edge", rsp_addr, 32'h0000_0200);
  endtask

  task automatic t_backpressure;
    // R10: ready passes back, valid passes forward, same cycle
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1;
    #1;
    check("R10 ready low", {31'd0, req_ready}, 32'd0);
    check("R10 valid high", {31'd0, rsp_valid}, 32'd1);
    @(negedge clk);
    rsp_ready = 1'b1; req_valid = 1'b0;
    #1;
    check("R10 ready high", {31'd0, req_ready}, 32'd1);
    check("R10 valid low", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_nonilv();
    t_xoroff();
    t_b11();
    t_b17();
    t_unknown();
    t_linear();
    t_family();
    t_cfg_timing();
    t_backpressure();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule